// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every reset request of a chip into one active-high system reset and keeps a sticky record of which sources have fired. The requests are power-on, brown-out, an active-low external reset pin, watchdog timeout, a software request and configuration mismatch. Power-on acts as the asynchronous reset of the block itself. All other requests are synchronous digital levels, except the pin. The pin passes through a two-flop synchronizer and a minimum-width filter, so short glitches are dropped.

The system reset is released only once both the configuration-loaded and clock-stable inputs are high. It then falls after a fixed delay of 8 clocks. A software reset needs a protected sequence of bus operations. Two key words are written to the key register with no bus transaction in between. The arm bit is then set in the software-reset register. A later read of that register fires the reset. Software reads the status register to find the cause and clears flags by writing ones.

The bus is a single-cycle register port. `bus_sel` marks one transaction per cycle, taken at the rising clock edge. Read data is valid in the same cycle as the request. Addresses: 0 status, 1 key, 2 software reset; address 3 reads zero.

Top module: `sysrst_hub`

## Requirements
- R1: A brown-out, watchdog or configuration-mismatch request seen at a rising edge drives `sys_rst` high after that edge. With the ready inputs high, `sys_rst` falls on the 9th rising edge after the last edge that saw the request.
- R2: The status register (address 0) holds one flag per source. The positions are: bit 0 power-on, bit 1 brown-out, bit 4 watchdog, bit 6 software, bit 7 external pin, bit 9 configuration mismatch. All other bits read 0.
- R3: Flags are sticky and survive every reset except power-on. Writing 1 to a status bit clears that flag; writing 0 leaves it unchanged.
- R4: A low `por_n` asserts `sys_rst` at once, sets the status register to 0x001 and clears the armed bit.
- R5: `sys_rst` stays high while `cfg_loaded` and `clk_stable` are not both high. With no request active, it falls on the 8th rising edge after the edge that first samples both inputs high.
- R6: A low level on `ext_rst_n` sampled at 4 (PIN_MIN_W) consecutive rising edges drives `sys_rst` high after the 7th edge counted from the first low sample, and sets flag bit 7. A low pulse sampled at fewer edges causes no reset and sets no flag.
- R7: The unlock sequence is a write of 0xAA996655 to address 1, then a write of 0x556699AA to address 1. A wrong value or any other bus transaction between the two writes returns the block to the locked state.
- R8: A write with bit 0 set to address 2 sets the armed bit only while unlocked. Any transaction after unlock consumes the unlock. Reading address 2 returns the armed bit in bit 0.
- R9: A read of address 2 while armed drives `sys_rst` high after the rising edge that follows the read's edge. It then clears the armed bit and sets flag bit 6. A read while not armed causes no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on request, active low, asynchronous |
| bor_req | input | 1 | Brown-out request level |
| wdt_req | input | 1 | Watchdog timeout request level |
| cfg_mm_req | input | 1 | Configuration mismatch request level |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| cfg_loaded | input | 1 | Configuration settings are loaded |
| clk_stable | input | 1 | Clock sources are stable |
| bus_sel | input | 1 | Bus transaction in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| sys_rst | output | 1 | System reset, active high |

## Verification
Every result has a fixed latency, and each check samples at a falling edge counted from the edge that takes the stimulus. A level request shows on `sys_rst` one edge later and releases nine edges after the request is removed. The release after power-on falls eight edges after the ready inputs are first sampled. A triggering read shows its reset two edges after the read's edge, and a pin pulse one edge after the filter count completes. Each check is taken on the edge just before and the edge just after the change, so an off-by-one in any counter or pipeline register is caught.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned STATUS_W = 10;

  localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] A_KEY    = 2'd1;
  localparam logic [ADDR_W-1:0] A_SWRST  = 2'd2;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'hAA99_6655;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'h5566_99AA;

  localparam int unsigned FLG_POWER = 0;
  localparam int unsigned FLG_BROWN = 1;
  localparam int unsigned FLG_WDOG  = 4;
  localparam int unsigned FLG_SW    = 6;
  localparam int unsigned FLG_PIN   = 7;
  localparam int unsigned FLG_CFG   = 9;

  // synchronous sources, index order of the request vector
  localparam int unsigned NSRC = 5;

  typedef enum logic [1:0] {SEQ_HOLD, SEQ_COUNT, SEQ_RUN} seq_state_t;
  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_state_t;

  function automatic int unsigned src_bit(input int unsigned idx);
    case (idx)
      0:       return FLG_BROWN;
      1:       return FLG_WDOG;
      2:       return FLG_CFG;
      3:       return FLG_PIN;
      default: return FLG_SW;
    endcase
  endfunction
endpackage

// File: rtl/sysrst_sync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES edges.
module sysrst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge async_n) begin
    if (!async_n) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sysrst_pin_filter.sv
// Synchronizes the active-low pin and reports a request once it has been
// low for MIN_W consecutive synchronized samples.
module sysrst_pin_filter #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned MIN_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic req
);
  localparam int unsigned CW = $clog2(MIN_W + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_W);

  logic [STAGES-1:0] sync_q;
  logic [CW-1:0]     low_cnt_q, low_cnt_nxt;
  logic              pin_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], pin_n};
  end

  assign pin_sync_n = sync_q[STAGES-1];

  always_comb begin
    low_cnt_nxt = low_cnt_q;
    if (pin_sync_n)              low_cnt_nxt = '0;
    else if (low_cnt_q != LIMIT) low_cnt_nxt = low_cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt_q <= '0;
    else        low_cnt_q <= low_cnt_nxt;
  end

  assign req = (low_cnt_q == LIMIT);
endmodule

// File: rtl/sysrst_swkey.sv
// Key-protected software reset: unlock sequencer, arm bit, trigger on read.
module sysrst_swkey
  import sysrst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              in_reset,
  output logic              armed,
  output logic              unlocked,
  output logic              fire
);
  unlock_state_t ul_q, ul_nxt;
  logic armed_q, armed_nxt;
  logic fire_q, fire_nxt;
  logic wr_key, wr_sw, rd_sw;

  assign wr_key = bus_sel &&  bus_wr && (bus_addr == A_KEY);
  assign wr_sw  = bus_sel &&  bus_wr && (bus_addr == A_SWRST);
  assign rd_sw  = bus_sel && !bus_wr && (bus_addr == A_SWRST);

  always_comb begin
    ul_nxt = ul_q;
    if (in_reset) begin
      ul_nxt = UL_IDLE;
    end else if (bus_sel) begin
      case (ul_q)
        UL_IDLE: ul_nxt = (wr_key && bus_wdata == KEY_FIRST)  ? UL_HALF : UL_IDLE;
        UL_HALF: ul_nxt = (wr_key && bus_wdata == KEY_SECOND) ? UL_OPEN : UL_IDLE;
        default: ul_nxt = UL_IDLE;
      endcase
    end
  end

  always_comb begin
    armed_nxt = armed_q;
    if (fire_q || in_reset)                         armed_nxt = 1'b0;
    else if (ul_q == UL_OPEN && wr_sw && bus_wdata[0]) armed_nxt = 1'b1;
  end

  assign fire_nxt = rd_sw && armed_q && !fire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ul_q    <= UL_IDLE;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      ul_q    <= ul_nxt;
      armed_q <= armed_nxt;
      fire_q  <= fire_nxt;
    end
  end

  assign armed    = armed_q;
  assign unlocked = (ul_q == UL_OPEN);
  assign fire     = fire_q;
endmodule

// File: rtl/sysrst_release.sv
// Holds the system reset while requests are active or readiness is missing,
// then counts DLY edges before release.
module sysrst_release
  import sysrst_pkg::*;
#(
  parameter int unsigned DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic ready,
  output logic sys_rst
);
  localparam int unsigned CNT_W = $clog2(DLY + 1);

  seq_state_t       state_q, state_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             rst_q;

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    if (any_req) begin
      state_nxt = SEQ_HOLD;
    end else begin
      case (state_q)
        SEQ_HOLD: if (ready) begin
          state_nxt = SEQ_COUNT;
          cnt_nxt   = CNT_W'(DLY - 1);
        end
        SEQ_COUNT: begin
          if (!ready)             state_nxt = SEQ_HOLD;
          else if (cnt_q == '0)   state_nxt = SEQ_RUN;
          else                    cnt_nxt   = cnt_q - CNT_W'(1);
        end
        SEQ_RUN:  state_nxt = SEQ_RUN;
        default:  state_nxt = SEQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_HOLD;
      cnt_q   <= '0;
      rst_q   <= 1'b1;
    end else begin
      state_q <= state_nxt;
      cnt_q   <= cnt_nxt;
      rst_q   <= (state_nxt != SEQ_RUN);
    end
  end

  assign sys_rst = rst_q;
endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub
  import sysrst_pkg::*;
#(
  parameter int unsigned RELEASE_DLY = 8,
  parameter int unsigned PIN_MIN_W   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              bor_req,
  input  logic              wdt_req,
  input  logic              cfg_mm_req,
  input  logic              ext_rst_n,
  input  logic              cfg_loaded,
  input  logic              clk_stable,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst
);
  localparam logic [STATUS_W-1:0] STATUS_INIT = STATUS_W'(1) << FLG_POWER;

  logic                rst_n;
  logic                pin_req, sw_fire, armed, unlocked, any_req;
  logic [NSRC-1:0]     src_req;
  logic [STATUS_W-1:0] status_q, status_nxt, set_vec, clr_vec;

  sysrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .async_n(por_n), .sync_n(rst_n)
  );

  sysrst_pin_filter #(.STAGES(SYNC_STAGES), .MIN_W(PIN_MIN_W)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_rst_n), .req(pin_req)
  );

  sysrst_swkey u_key (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .in_reset(sys_rst),
    .armed(armed), .unlocked(unlocked), .fire(sw_fire)
  );

  assign src_req = {sw_fire, pin_req, cfg_mm_req, wdt_req, bor_req};
  assign any_req = |src_req;

  sysrst_release #(.DLY(RELEASE_DLY)) u_rel (
    .clk(clk), .rst_n(rst_n), .any_req(any_req),
    .ready(cfg_loaded && clk_stable), .sys_rst(sys_rst)
  );

  // status: sets win over write-one-to-clear in the same cycle
  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NSRC; i++) set_vec[src_bit(i)] = src_req[i];
    clr_vec = (bus_sel && bus_wr && bus_addr == A_STATUS) ?
              bus_wdata[STATUS_W-1:0] : '0;
    status_nxt = (status_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= STATUS_INIT;
    else        status_q <= status_nxt;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_STATUS: bus_rdata = {{(DATA_W-STATUS_W){1'b0}}, status_q};
        A_SWRST:  bus_rdata = {{(DATA_W-1){1'b0}}, armed};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sysrst_hub_chk.sv
module sysrst_hub_chk (
  input logic clk,
  input logic por_n,
  input logic lvl_req,
  input logic ready,
  input logic sys_rst,
  input logic sw_read,
  input logic armed,
  input logic unlocked,
  input logic pin_flag,
  input logic pin_clear,
  input logic sw_flag,
  input logic sw_clear
);
  // R1: level requests reach the reset output one edge later
  assert_level_req_R1: assert property (@(posedge clk) disable iff (!por_n)
    lvl_req |=> sys_rst);

  // R3: pin and software flags stay set until cleared by software
  assert_pin_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
    (pin_flag && !pin_clear) |=> pin_flag);
  assert_sw_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
    (sw_flag && !sw_clear) |=> sw_flag);

  // R5: release only happens with readiness present
  assert_release_ready_R5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> $past(ready));

  // R8: arming requires a completed unlock
  assert_arm_unlock_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(armed) |-> $past(unlocked));

  // R9: armed read fires the reset two edges on
  assert_trigger_R9: assert property (@(posedge clk) disable iff (!por_n)
    (sw_read && armed) |=> ##1 sys_rst);
endmodule

bind sysrst_hub sysrst_hub_chk u_chk (
  .clk(clk),
  .por_n(por_n),
  .lvl_req(bor_req || wdt_req || cfg_mm_req),
  .ready(cfg_loaded && clk_stable),
  .sys_rst(sys_rst),
  .sw_read(bus_sel && !bus_wr && bus_addr == sysrst_pkg::A_SWRST),
  .armed(armed),
  .unlocked(unlocked),
  .pin_flag(status_q[sysrst_pkg::FLG_PIN]),
  .pin_clear(bus_sel && bus_wr && bus_addr == sysrst_pkg::A_STATUS && bus_wdata[sysrst_pkg::FLG_PIN]),
  .sw_flag(status_q[sysrst_pkg::FLG_SW]),
  .sw_clear(bus_sel && bus_wr && bus_addr == sysrst_pkg::A_STATUS && bus_wdata[sysrst_pkg::FLG_SW])
);

// File: tb/sysrst_hub_test.sv
module sysrst_hub_test;
  logic        clk = 1'b0;
  logic        por_n, bor_req, wdt_req, cfg_mm_req, ext_rst_n;
  logic        cfg_loaded, clk_stable, bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rd;
  logic        sys_rst;
  int          n_chk = 0, n_fail = 0;

  localparam logic [31:0] K1 = 32'hAA99_6655, K2 = 32'h5566_99AA;

  always #10 clk = ~clk;

  sysrst_hub uut (
    .clk(clk), .por_n(por_n), .bor_req(bor_req), .wdt_req(wdt_req),
    .cfg_mm_req(cfg_mm_req), .ext_rst_n(ext_rst_n), .cfg_loaded(cfg_loaded),
    .clk_stable(clk_stable), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst(sys_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_release();
    for (int i = 0; i < 40 && sys_rst; i++) @(negedge clk);
  endtask

  task automatic t_power_on();
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 reset asserted", {31'b0, sys_rst}, 32'h1);
    rdreg(2'd0, rd);
    check("R4 status after power-on", rd, 32'h001);
    por_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R5 held without ready", {31'b0, sys_rst}, 32'h1);
    cfg_loaded = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 held with one ready input", {31'b0, sys_rst}, 32'h1);
    clk_stable = 1'b1;
    repeat (8) @(negedge clk);
    check("R5 still high after 7 edges", {31'b0, sys_rst}, 32'h1);
    @(negedge clk);
    check("R5 released on 8th edge", {31'b0, sys_rst}, 32'h0);
    wr(2'd0, 32'h001);
    rdreg(2'd0, rd);
    check("R3 write-one clears power flag", rd, 32'h0);
  endtask

  task automatic t_level(input int which, input logic [31:0] flag, input string tag);
    case (which)
      0: bor_req = 1'b1;
      1: wdt_req = 1'b1;
      default: cfg_mm_req = 1'b1;
    endcase
    @(negedge clk);
    bor_req = 1'b0; wdt_req = 1'b0; cfg_mm_req = 1'b0;
    check({"R1 reset raised ", tag}, {31'b0, sys_rst}, 32'h1);
    repeat (8) @(negedge clk);
    check({"R1 still high at 8th edge ", tag}, {31'b0, sys_rst}, 32'h1);
    @(negedge clk);
    check({"R1 released at 9th edge ", tag}, {31'b0, sys_rst}, 32'h0);
    rdreg(2'd0, rd);
    check({"R2 flag position ", tag}, rd, flag);
    wr(2'd0, 32'h0);
    rdreg(2'd0, rd);
    check({"R3 write of zero keeps flag ", tag}, rd, flag);
    wr(2'd0, flag);
    rdreg(2'd0, rd);
    check({"R3 flag cleared ", tag}, rd, 32'h0);
  endtask

  task automatic t_sw_good();
    wr(2'd1, K1);
    wr(2'd1, K2);
    wr(2'd2, 32'h1);
    rdreg(2'd2, rd);
    check("R8 armed after unlock", rd, 32'h1);
    check("R9 no reset on read edge", {31'b0, sys_rst}, 32'h0);
    @(negedge clk);
    check("R9 reset on following edge", {31'b0, sys_rst}, 32'h1);
    wait_release();
    rdreg(2'd0, rd);
    check("R9 software flag bit 6", rd, 32'h040);
    rdreg(2'd2, rd);
    check("R9 armed cleared", rd, 32'h0);
    repeat (3) @(negedge clk);
    check("R9 unarmed read gives no reset", {31'b0, sys_rst}, 32'h0);
    wr(2'd0, 32'h040);
  endtask

  task automatic try_arm(input string tag);
    wr(2'd2, 32'h1);
    rdreg(2'd2, rd);
    check(tag, rd, 32'h0);
    repeat (2) @(negedge clk);
    check({tag, " no reset"}, {31'b0, sys_rst}, 32'h0);
  endtask

  task automatic t_sw_bad();
    wr(2'd1, K1); wr(2'd1, 32'h1234_5678); wr(2'd1, K2);
    try_arm("R7 wrong key rejected");
    wr(2'd1, K1); rdreg(2'd0, rd); wr(2'd1, K2);
    try_arm("R7 interrupted sequence rejected");
    wr(2'd1, K2); wr(2'd1, K1);
    try_arm("R7 reversed keys rejected");
    try_arm("R8 arm without unlock ignored");
    wr(2'd1, K1); wr(2'd1, K2); rdreg(2'd0, rd); wr(2'd2, 32'h1);
    rdreg(2'd2, rd);
    check("R8 unlock consumed by other transaction", rd, 32'h0);
  endtask

  task automatic t_pin();
    ext_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R6 short pulse filtered", {31'b0, sys_rst}, 32'h0);
    rdreg(2'd0, rd);
    check("R6 short pulse sets no flag", rd, 32'h0);
    ext_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 no reset after 6th edge", {31'b0, sys_rst}, 32'h0);
    @(negedge clk);
    check("R6 reset after 7th edge", {31'b0, sys_rst}, 32'h1);
    wait_release();
    rdreg(2'd0, rd);
    check("R6 pin flag bit 7", rd, 32'h080);
  endtask

  task automatic t_por_clears();
    bor_req = 1'b1;
    @(negedge clk);
    bor_req = 1'b0;
    wait_release();
    rdreg(2'd0, rd);
    check("R3 pin flag survives brown-out reset", rd, 32'h082);
    por_n = 1'b0;
    @(negedge clk);
    check("R4 power-on asserts reset", {31'b0, sys_rst}, 32'h1);
    rdreg(2'd0, rd);
    check("R4 power-on clears other flags", rd, 32'h001);
    por_n = 1'b1;
    wait_release();
    check("R5 released again", {31'b0, sys_rst}, 32'h0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    por_n = 1'b0; bor_req = 1'b0; wdt_req = 1'b0; cfg_mm_req = 1'b0;
    ext_rst_n = 1'b1; cfg_loaded = 1'b0; clk_stable = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 32'h0;
    @(negedge clk);
    t_power_on();
    t_level(0, 32'h002, "brown-out");
    t_level(1, 32'h010, "watchdog");
    t_level(2, 32'h200, "config mismatch");
    t_sw_good();
    t_sw_bad();
    t_pin();
    t_por_clears();
    finish_up();
  end
endmodule